// File: doc/BRIEF.md
# Buffered Input Capture Bank

This block provides a bank of input capture channels that share one free-running timer value. Each channel has a two-flop synchronizer and a per-channel edge selector. On every qualifying pin edge the channel stores the current timer value in its capture register and increments an 8-bit saturating edge counter. Behind each capture register sits one holding register. A second holding register stands behind each edge counter.

One mode input sets how the holding registers are filled. In queue mode, every capture first pushes the old capture value into the holding register, so the last two capture times are both kept. In latch mode, pin edges touch only the capture register and the counter. A one-cycle latch strobe then copies every channel's capture value and counter value into its holding registers at the same time, and clears all counters. The latch strobe comes from an external modulus down-counter, either when it reaches zero or when software loads it with zero.

All registers can be read through a combinational address-to-data port.

Top module: `ic_capture_bank`

The per-channel edge logic is a two-state machine with the states PIN_LOW and PIN_HIGH. The transition from PIN_LOW to PIN_HIGH is a rising edge, and the transition from PIN_HIGH to PIN_LOW is a falling edge.

Each channel resolves one action per cycle:
- ACT_IDLE: nothing happens.
- ACT_PUSH: a queue-mode capture.
- ACT_CAP: a latch-mode capture.
- ACT_SNAP: a latch-mode strobe alone.
- ACT_SNAP_CAP: a latch-mode strobe and an edge in the same cycle.

## Requirements
- R1: After reset, the capture, holding, counter and counter-holding registers of every channel read zero, and the edge state is PIN_LOW.
- R2: The 2-bit edge field of channel n is `edge_cfg[2n+1:2n]`. The value 0 disables the channel, 1 selects rising edges, 2 selects falling edges and 3 selects both edges. An edge that is not selected changes no register.
- R3: After a pin change, the capture register holds the timer value present at the third rising clock edge after the pin change. The pin is first sampled at the first of those edges.
- R4: In queue mode (`mode_latch`=0), a qualifying edge moves the old capture value into the holding register and loads the timer value into the capture register in the same cycle.
- R5: In latch mode (`mode_latch`=1), a qualifying edge updates only the capture register and the counter. Both holding registers stay unchanged.
- R6: In latch mode, a `latch_evt` pulse copies every channel's capture value to its holding register and its counter value to its counter-holding register, and clears every counter.
- R7: In queue mode, `latch_evt` has no effect on any register.
- R8: In both modes, the counter increments by one per qualifying edge and stops at 255.
- R9: If an edge and a latch pulse occur in the same cycle in latch mode, the holding registers take the values from before the edge. The capture register takes the new timer value, and the counter becomes 1.
- R10: `rd_data` is combinational from `rd_addr`. The address is formed as {channel, sel}, with sel in bits [1:0]. Sel 0 reads the capture register, 1 the holding register, 2 the counter (zero-extended) and 3 the counter-holding register (zero-extended).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_latch | input | 1 | 0 selects queue mode, 1 selects latch mode |
| edge_cfg | input | 2*NCH | Edge selection field for each channel |
| pin_i | input | NCH | Asynchronous capture pins |
| timer_i | input | TW | Shared free-running timer value |
| latch_evt | input | 1 | One-cycle latch strobe from the modulus counter |
| rd_addr | input | CW+2 | Read address {channel, sel} |
| rd_data | output | TW | Read data |

## Verification
The embedded assertions check the following on every cycle:
- A disabled channel never reports an edge.
- A queue-mode push places the previous capture value into the holding register.
- The holding registers stay stable for latch-mode edges without a strobe.
- The counter-holding register ignores strobes in queue mode.
- The counter never decreases except through a latch clear.
- A coincident edge and strobe leave a counter value of 1.

Other behaviours can only be shown through the bench's scenarios:
- The exact three-edge capture latency against a moving timer.
- The behaviour of each edge-select code for both pin directions.
- Saturation after hundreds of edges.
- The correct routing of every register through the read address.

// File: rtl/ic_pkg.sv
package ic_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    typedef enum logic [2:0] {
        ACT_IDLE     = 3'd0,
        ACT_PUSH     = 3'd1,
        ACT_CAP      = 3'd2,
        ACT_SNAP     = 3'd3,
        ACT_SNAP_CAP = 3'd4
    } chan_act_e;

    typedef enum logic [1:0] {
        SEL_CAP      = 2'd0,
        SEL_HOLD     = 2'd1,
        SEL_ACC      = 2'd2,
        SEL_ACC_HOLD = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/ic_edge_fsm.sv
module ic_edge_fsm
    import ic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] cfg_i,
    output logic       edge_o
);
    logic        meta_q;
    logic        sync_q;
    pin_state_e  state_q;
    pin_state_e  state_d;
    logic        rise;
    logic        fall;
    edge_sel_e   sel;

    assign sel = edge_sel_e'(cfg_i);

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    // next state and edge outputs
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            PIN_LOW: begin
                if (sync_q) begin
                    state_d = PIN_HIGH;
                    rise    = 1'b1;
                end
            end
            PIN_HIGH: begin
                if (!sync_q) begin
                    state_d = PIN_LOW;
                    fall    = 1'b1;
                end
            end
            default: state_d = PIN_LOW;
        endcase
    end

    always_comb begin
        unique case (sel)
            EDGE_OFF:  edge_o = 1'b0;
            EDGE_RISE: edge_o = rise;
            EDGE_FALL: edge_o = fall;
            EDGE_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end

    // R2
    edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_OFF) |-> !edge_o);
endmodule

// File: rtl/ic_chan.sv
module ic_chan
    import ic_pkg::*;
#(
    parameter int TW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_i,
    input  logic [TW-1:0] timer_i,
    input  logic          mode_latch_i,
    input  logic          latch_evt_i,
    output logic [TW-1:0] cap_o,
    output logic [TW-1:0] hold_o,
    output logic [AW-1:0] acc_o,
    output logic [AW-1:0] acc_hold_o
);
    localparam logic [AW-1:0] ACC_MAX = {AW{1'b1}};
    localparam logic [AW-1:0] ACC_ONE = AW'(1);

    logic [TW-1:0] cap_q, hold_q;
    logic [AW-1:0] acc_q, acch_q;
    logic [AW-1:0] acc_inc;
    chan_act_e     act;

    assign acc_inc = (acc_q == ACC_MAX) ? acc_q : acc_q + ACC_ONE;

    // action decode
    always_comb begin
        act = ACT_IDLE;
        if (!mode_latch_i) begin
            if (edge_i) act = ACT_PUSH;
        end else begin
            unique case ({latch_evt_i, edge_i})
                2'b01:   act = ACT_CAP;
                2'b10:   act = ACT_SNAP;
                2'b11:   act = ACT_SNAP_CAP;
                default: act = ACT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= '0;
            hold_q <= '0;
            acc_q  <= '0;
            acch_q <= '0;
        end else begin
            unique case (act)
                ACT_IDLE: ;
                ACT_PUSH: begin
                    hold_q <= cap_q;
                    cap_q  <= timer_i;
                    acc_q  <= acc_inc;
                end
                ACT_CAP: begin
                    cap_q <= timer_i;
                    acc_q <= acc_inc;
                end
                ACT_SNAP: begin
                    hold_q <= cap_q;
                    acch_q <= acc_q;
                    acc_q  <= '0;
                end
                ACT_SNAP_CAP: begin
                    hold_q <= cap_q;
                    acch_q <= acc_q;
                    cap_q  <= timer_i;
                    acc_q  <= ACC_ONE;
                end
                default: ;
            endcase
        end
    end

    assign cap_o      = cap_q;
    assign hold_o     = hold_q;
    assign acc_o      = acc_q;
    assign acc_hold_o = acch_q;

    // R4
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !mode_latch_i) |=> (hold_o == $past(cap_o)));
    // R5
    latch_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && mode_latch_i && !latch_evt_i) |=> ($stable(hold_o) && $stable(acc_hold_o)));
    // R6
    snap_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_latch_i && latch_evt_i) |=> (acc_hold_o == $past(acc_o)));
    // R7
    queue_evt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_latch_i) |=> $stable(acc_hold_o));
    // R8
    acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_latch_i && latch_evt_i) |=> (acc_o >= $past(acc_o)));
    // R9
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && mode_latch_i && latch_evt_i) |=> (acc_o == ACC_ONE && hold_o == $past(cap_o)));
endmodule

// File: rtl/ic_capture_bank.sv
module ic_capture_bank
    import ic_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 16,
    parameter int AW  = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_latch,
    input  logic [2*NCH-1:0] edge_cfg,
    input  logic [NCH-1:0]   pin_i,
    input  logic [TW-1:0]    timer_i,
    input  logic             latch_evt,
    input  logic [CW+1:0]    rd_addr,
    output logic [TW-1:0]    rd_data
);
    logic [TW-1:0] cap_w  [NCH];
    logic [TW-1:0] hold_w [NCH];
    logic [AW-1:0] acc_w  [NCH];
    logic [AW-1:0] acch_w [NCH];
    logic [NCH-1:0] edge_w;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ic_edge_fsm u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[g]),
            .cfg_i  (edge_cfg[2*g +: 2]),
            .edge_o (edge_w[g])
        );
        ic_chan #(.TW(TW), .AW(AW)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .edge_i       (edge_w[g]),
            .timer_i      (timer_i),
            .mode_latch_i (mode_latch),
            .latch_evt_i  (latch_evt),
            .cap_o        (cap_w[g]),
            .hold_o       (hold_w[g]),
            .acc_o        (acc_w[g]),
            .acc_hold_o   (acch_w[g])
        );
    end

    logic [CW-1:0] ch;
    rd_sel_e       sel;
    assign ch  = rd_addr[CW+1:2];
    assign sel = rd_sel_e'(rd_addr[1:0]);

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_CAP:      rd_data = cap_w[ch];
            SEL_HOLD:     rd_data = hold_w[ch];
            SEL_ACC:      rd_data = TW'(acc_w[ch]);
            SEL_ACC_HOLD: rd_data = TW'(acch_w[ch]);
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: tb/tb_ic_capture_bank.sv
`timescale 1ns/1ps
module tb_ic_capture_bank;
    localparam int NCH = 4;
    localparam int TW  = 16;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_latch = 1'b0;
    logic [2*NCH-1:0] edge_cfg = '0;
    logic [NCH-1:0] pin_i = '0;
    logic [TW-1:0] tmr = 16'h1000;
    logic latch_evt = 1'b0;
    logic [CW+1:0] rd_addr = '0;
    logic [TW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int cap_m [NCH];
    int hold_m[NCH];
    int acc_m [NCH];
    int acch_m[NCH];

    always #2 clk = ~clk;
    always @(posedge clk) tmr <= tmr + 16'd1;

    ic_capture_bank #(.NCH(NCH), .TW(TW), .AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .mode_latch(mode_latch), .edge_cfg(edge_cfg),
        .pin_i(pin_i), .timer_i(tmr), .latch_evt(latch_evt),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // R10: read all registers through {channel, sel}
    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 4; s++) begin
                int e;
                rd_addr = 4'((c << 2) | s);
                #0.1;
                e = (s == 0) ? cap_m[c] : (s == 1) ? hold_m[c] : (s == 2) ? acc_m[c] : acch_m[c];
                chk($sformatf("%s/R10 ch%0d sel%0d", req, c, s), int'(rd_data), e);
            end
        end
    endtask

    function automatic bit qualifies(input int cfg, input bit rising);
        return (cfg == 3) || (cfg == 1 && rising) || (cfg == 2 && !rising);
    endfunction

    function automatic void model_edge(input int c, input int t);
        if (mode_latch == 1'b0) hold_m[c] = cap_m[c];
        cap_m[c] = t & 16'hFFFF;
        acc_m[c] = (acc_m[c] >= 255) ? 255 : acc_m[c] + 1;
    endfunction

    function automatic void model_snap();
        for (int c = 0; c < NCH; c++) begin
            hold_m[c] = cap_m[c];
            acch_m[c] = acc_m[c];
            acc_m[c]  = 0;
        end
    endfunction

    // R3: pin driven at a negedge; captured timer is the value at the 3rd posedge
    task automatic pin_step(input int c, input bit lvl, input bit with_latch);
        int t0;
        bit rising;
        @(negedge clk);
        rising = lvl && !pin_i[c];
        t0 = int'(tmr);
        pin_i[c] = lvl;
        @(negedge clk);
        @(negedge clk);
        if (with_latch) latch_evt = 1'b1;
        @(negedge clk);
        latch_evt = 1'b0;
        if (with_latch && mode_latch) model_snap();
        if (qualifies(int'(edge_cfg[2*c +: 2]), rising)) begin
            model_edge(c, t0 + 2);
            if (with_latch && mode_latch) acc_m[c] = 1;
        end
    endtask

    task automatic pulse_latch();
        @(negedge clk);
        latch_evt = 1'b1;
        @(negedge clk);
        latch_evt = 1'b0;
        if (mode_latch) model_snap();
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            cap_m[c] = 0; hold_m[c] = 0; acc_m[c] = 0; acch_m[c] = 0;
        end
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;

        // R2/R3/R4: sweep every edge code on every channel, queue mode
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int c = 0; c < NCH; c++) edge_cfg[2*c +: 2] = 2'(cfg);
            for (int c = 0; c < NCH; c++) begin
                pin_step(c, 1'b1, 1'b0);
                check_all($sformatf("R2 R3 R4 cfg%0d rise", cfg));
                pin_step(c, 1'b0, 1'b0);
                check_all($sformatf("R2 R3 R4 cfg%0d fall", cfg));
            end
        end

        // R7: strobe in queue mode changes nothing
        pulse_latch();
        check_all("R7 queue strobe");
        pin_step(1, 1'b1, 1'b1);
        check_all("R7 queue strobe with edge");

        // R5: latch mode edges leave holding registers alone
        mode_latch = 1'b1;
        edge_cfg = {NCH{2'd3}};
        pin_step(0, 1'b1, 1'b0);
        pin_step(2, 1'b1, 1'b0);
        pin_step(2, 1'b0, 1'b0);
        check_all("R5 latch edges");

        // R6: strobe snapshots all channels and clears counters
        pulse_latch();
        check_all("R6 snapshot");

        // R9: coincident edge and strobe
        pin_step(3, 1'b1, 1'b0);
        pin_step(0, 1'b0, 1'b1);
        check_all("R9 coincident");

        // R8: saturation after many edges, both-edge mode
        @(negedge clk);
        for (int k = 0; k < 600; k++) begin
            pin_i[1] = ~pin_i[1];
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        rd_addr = 4'((1 << 2) | 2);
        #0.1;
        chk("R8 saturate", int'(rd_data), 255);
        pulse_latch();
        rd_addr = 4'((1 << 2) | 3);
        #0.1;
        chk("R8/R6 saturated snapshot", int'(rd_data), 255);
        rd_addr = 4'((1 << 2) | 2);
        #0.1;
        chk("R6 cleared", int'(rd_data), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule